// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Register Loader

This block keeps the two threshold values that a FIFO's programmable flag logic compares against: the almost-empty offset and the almost-full offset. While master reset is held, it takes a pair of defaults picked by three select pins. In the same window it latches the loading method, the write and read port widths, and the parity-bit placement. After reset, software can rewrite the offsets one bit at a time through a serial input. It can instead rewrite them one bus word at a time through the parallel data bus. Which of the two is used depends on the method latched at reset.

The current offsets can be read back at any time as a sequence of words on the parallel output bus. The read-back works in either loading method. The load-select input `ofsLd` gates every access: when it is low, the serial, parallel-write and read-back strobes are ignored. When it is low it also rewinds every sequencing pointer to the first word or bit of the almost-empty offset.

All activity is synchronous to one clock. Offsets are `$clog2(DEPTH)` bits wide, so any value from 0 to DEPTH-1 can be stored.

Top module: `ofs_loader`

## Requirements
- R1: While `mstRst` is high, the loading method is latched from `ofsLd` (1 = serial, 0 = parallel), along with `wrWideIn`, `rdWideIn` and `parityIn`. These settings hold unchanged until the next master reset.
- R2: While `mstRst` is high, both offsets are set to min(2^(k+3)-1, DEPTH-1), where k = {ofsLd, fsel1, fsel0} read as a 3-bit number. `rdData` is cleared to zero.
- R3: In serial mode, each clock with `ofsLd` and `serEn` high stores `serIn` as the next bit. The almost-empty offset is filled first, least significant bit first, and the almost-full offset follows in the same way.
- R4: Once 2*OFS_W serial bits have been stored, further serial bits change nothing until `ofsLd` goes low. The next serial bit after that goes to bit 0 of the almost-empty offset.
- R5: In parallel mode, each clock with `ofsLd` and `wrEn` high loads the next word. The order is the almost-empty words, lowest word first, then the almost-full words. A register takes ceil(OFS_W/16) words on a wide write port and ceil(OFS_W/8) words on a narrow one, which is 1 and 2 words at the default DEPTH of 1024.
- R6: Parallel word field: on a narrow port, bits [7:0] are used. On a wide port with parity placement set, bits {[16:9],[7:0]} are used and bits 8 and 17 are skipped. On a wide port without it, bits [15:0] are used and bits 16 and 17 are ignored.
- R7: Each clock with `ofsLd` and `rdEn` high puts the next offset word on `rdData` in the next cycle. The order is the same as R5, the read width is latched from `rdWideIn`, and the bit placement mirrors R6 with unused bits zero. This works in both loading methods. `rdData` holds its value otherwise.
- R8: In serial mode `wrEn` never changes the offsets. In parallel mode `serEn` never changes them.
- R9: With `ofsLd` low, `wrEn`, `serEn` and `rdEn` change neither the offsets nor `rdData`.
- R10: The write and read-back word pointers wrap from the last almost-full word back to the first almost-empty word. Taking `ofsLd` low returns both pointers to the first almost-empty word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| mstRst | input | 1 | Synchronous master reset, active high |
| ofsLd | input | 1 | Method/default select during reset; access gate afterwards |
| fsel0 | input | 1 | Default select bit 0 (sampled in reset) |
| fsel1 | input | 1 | Default select bit 1 (sampled in reset) |
| wrWideIn | input | 1 | 1 = wide (18-bit) write port, sampled in reset |
| rdWideIn | input | 1 | 1 = wide (18-bit) read port, sampled in reset |
| parityIn | input | 1 | 1 = parity bit placed inside wide words, sampled in reset |
| serEn | input | 1 | Serial bit strobe |
| serIn | input | 1 | Serial data bit |
| wrEn | input | 1 | Parallel word write strobe |
| dIn | input | 18 | Parallel word input |
| rdEn | input | 1 | Read-back strobe |
| emptyOfs | output | $clog2(DEPTH) | Almost-empty offset |
| fullOfs | output | $clog2(DEPTH) | Almost-full offset |
| rdData | output | 18 | Read-back word |

## Verification
A serial bit counter that drifts puts a bit into the wrong register or the wrong position. The offset outputs show this on the clock edge that stores the bit. A word pointer that skips or fails to rewind loads a byte into the wrong half. This shows on the offset outputs one cycle after the strobe. A wrongly latched width or parity setting shows on the first parallel load or read-back after reset. The read-back path exposes read-pointer errors on `rdData` one cycle after each strobe, including the wrap past the last word.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  // Strobes and latched settings passed from control to datapath
  typedef struct packed {
    logic serWrite;   // store one serial bit
    logic parWrite;   // store one parallel word
    logic rdStb;      // present one read-back word
    logic wrWide;     // write port is wide
    logic rdWide;     // read port is wide
    logic parIntr;    // parity bit placed inside wide words
  } ofsStb_t;

  localparam int BUS_W = 18;
  localparam int FIELD_W = 16;

endpackage

// File: rtl/ofs_ctrl.sv
module ofs_ctrl
  import ofs_pkg::*;
#(
  parameter int OFS_W = 10,
  parameter int SCW = 5,
  parameter int PW = 2,
  parameter int WN = 2,
  parameter int WW = 1
) (
  input  logic          clk,
  input  logic          mstRst,
  input  logic          ofsLd,
  input  logic          wrWideIn,
  input  logic          rdWideIn,
  input  logic          parityIn,
  input  logic          serEn,
  input  logic          wrEn,
  input  logic          rdEn,
  output ofsStb_t       stb,
  output logic [SCW-1:0] serBit,
  output logic [PW-1:0]  wrPtr,
  output logic [PW-1:0]  rdPtr
);

  localparam int SMAX = 2 * OFS_W;

  logic serMode, wrWide, rdWide, parIntr;
  logic [SCW-1:0] sCnt;
  logic [PW-1:0]  wrP, rdP;
  logic           sDone;
  logic [PW-1:0]  wrLast, rdLast;

  assign sDone  = (sCnt == SCW'(SMAX));
  assign wrLast = wrWide ? PW'(2 * WW - 1) : PW'(2 * WN - 1);
  assign rdLast = rdWide ? PW'(2 * WW - 1) : PW'(2 * WN - 1);

  always_ff @(posedge clk) begin
    if (mstRst) begin
      serMode <= ofsLd;
      wrWide  <= wrWideIn;
      rdWide  <= rdWideIn;
      parIntr <= parityIn;
      sCnt    <= '0;
      wrP     <= '0;
      rdP     <= '0;
    end else if (!ofsLd) begin
      sCnt <= '0;
      wrP  <= '0;
      rdP  <= '0;
    end else begin
      if (serMode && serEn && !sDone) sCnt <= sCnt + 1'b1;
      if (!serMode && wrEn) wrP <= (wrP == wrLast) ? '0 : wrP + 1'b1;
      if (rdEn) rdP <= (rdP == rdLast) ? '0 : rdP + 1'b1;
    end
  end

  always_comb begin
    stb.serWrite = ofsLd && serMode && serEn && !sDone;
    stb.parWrite = ofsLd && !serMode && wrEn;
    stb.rdStb    = ofsLd && rdEn;
    stb.wrWide   = wrWide;
    stb.rdWide   = rdWide;
    stb.parIntr  = parIntr;
  end

  assign serBit = sCnt;
  assign wrPtr  = wrP;
  assign rdPtr  = rdP;

  // R1: latched settings hold outside master reset
  p_mode_hold_r1: assert property (@(posedge clk) disable iff (mstRst)
    !$past(mstRst) |-> $stable({serMode, wrWide, rdWide, parIntr}));

  // R4: a finished serial load stays finished while ofsLd is held
  p_ser_stop_r4: assert property (@(posedge clk) disable iff (mstRst)
    (sDone && ofsLd) |=> sDone);

  // R3: every stored serial bit advances the bit position by one
  p_ser_step_r3: assert property (@(posedge clk) disable iff (mstRst)
    stb.serWrite |=> (sCnt == $past(sCnt) + 1'b1));

  // R10: dropping ofsLd rewinds all sequencing
  p_rewind_r10: assert property (@(posedge clk) disable iff (mstRst)
    !ofsLd |=> (sCnt == '0 && wrP == '0 && rdP == '0));

endmodule

// File: rtl/ofs_dpath.sv
module ofs_dpath
  import ofs_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int OFS_W = 10,
  parameter int SCW = 5,
  parameter int PW = 2,
  parameter int WN = 2,
  parameter int WW = 1
) (
  input  logic             clk,
  input  logic             mstRst,
  input  logic             ofsLd,
  input  logic             fsel1,
  input  logic             fsel0,
  input  ofsStb_t          stb,
  input  logic [SCW-1:0]   serBit,
  input  logic             serIn,
  input  logic [PW-1:0]    wrPtr,
  input  logic [PW-1:0]    rdPtr,
  input  logic [BUS_W-1:0] dIn,
  output logic [OFS_W-1:0] emptyOfs,
  output logic [OFS_W-1:0] fullOfs,
  output logic [BUS_W-1:0] rdData
);

  logic [OFS_W-1:0] emptyR, fullR;
  logic [OFS_W-1:0] defVal;
  logic [FIELD_W-1:0] inField, outField;
  logic [2*OFS_W-1:0] serNext;
  logic [OFS_W-1:0] parNext, rdSrc;
  logic wrHi, rdHi;
  logic [PW-1:0] wrK, rdK, wrWords, rdWords;
  logic [BUS_W-1:0] rdWord;

  function automatic logic [OFS_W-1:0] pickDefault(input logic [2:0] idx);
    logic [31:0] v;
    v = (32'd1 << (32'(idx) + 32'd3)) - 32'd1;
    if (v > 32'(DEPTH - 1)) v = 32'(DEPTH - 1);
    return v[OFS_W-1:0];
  endfunction

  assign defVal = pickDefault({ofsLd, fsel1, fsel0});

  // Parallel word field extraction
  always_comb begin
    if (!stb.wrWide)      inField = {8'b0, dIn[7:0]};
    else if (stb.parIntr) inField = {dIn[16:9], dIn[7:0]};
    else                  inField = dIn[15:0];
  end

  // Word pointer decode: which register, which word inside it
  always_comb begin
    wrWords = stb.wrWide ? PW'(WW) : PW'(WN);
    rdWords = stb.rdWide ? PW'(WW) : PW'(WN);
    wrHi = (wrPtr >= wrWords);
    rdHi = (rdPtr >= rdWords);
    wrK  = wrHi ? wrPtr - wrWords : wrPtr;
    rdK  = rdHi ? rdPtr - rdWords : rdPtr;
  end

  // Serial: combined vector, almost-empty in the low half
  always_comb begin
    serNext = {fullR, emptyR};
    for (int j = 0; j < 2 * OFS_W; j++)
      if (int'(serBit) == j) serNext[j] = serIn;
  end

  // Parallel: merge the field into the selected register's word
  always_comb begin
    parNext = wrHi ? fullR : emptyR;
    for (int i = 0; i < OFS_W; i++) begin
      if (stb.wrWide) begin
        if (int'(wrK) == i / 16) parNext[i] = inField[i % 16];
      end else begin
        if (int'(wrK) == i / 8) parNext[i] = inField[i % 8];
      end
    end
  end

  // Read-back: gather the selected word and place it on the bus
  always_comb begin
    rdSrc = rdHi ? fullR : emptyR;
    outField = '0;
    for (int i = 0; i < OFS_W; i++) begin
      if (stb.rdWide) begin
        if (int'(rdK) == i / 16) outField[i % 16] = rdSrc[i];
      end else begin
        if (int'(rdK) == i / 8) outField[i % 8] = rdSrc[i];
      end
    end
    if (!stb.rdWide)      rdWord = {10'b0, outField[7:0]};
    else if (stb.parIntr) rdWord = {1'b0, outField[15:8], 1'b0, outField[7:0]};
    else                  rdWord = {2'b0, outField};
  end

  always_ff @(posedge clk) begin
    if (mstRst) begin
      emptyR <= defVal;
      fullR  <= defVal;
      rdData <= '0;
    end else begin
      if (stb.serWrite) begin
        emptyR <= serNext[OFS_W-1:0];
        fullR  <= serNext[2*OFS_W-1:OFS_W];
      end else if (stb.parWrite) begin
        if (wrHi) fullR <= parNext;
        else      emptyR <= parNext;
      end
      if (stb.rdStb) rdData <= rdWord;
    end
  end

  assign emptyOfs = emptyR;
  assign fullOfs  = fullR;

  // R9/R8: offsets move only on a control strobe
  p_ofs_hold_r9: assert property (@(posedge clk) disable iff (mstRst)
    !(stb.serWrite || stb.parWrite) |=> $stable({emptyR, fullR}));

  // R7: read-back word holds between read strobes
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (mstRst)
    !stb.rdStb |=> $stable(rdData));

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int OFS_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             mstRst,
  input  logic             ofsLd,
  input  logic             fsel0,
  input  logic             fsel1,
  input  logic             wrWideIn,
  input  logic             rdWideIn,
  input  logic             parityIn,
  input  logic             serEn,
  input  logic             serIn,
  input  logic             wrEn,
  input  logic [17:0]      dIn,
  input  logic             rdEn,
  output logic [OFS_W-1:0] emptyOfs,
  output logic [OFS_W-1:0] fullOfs,
  output logic [17:0]      rdData
);

  localparam int WN  = (OFS_W + 7) / 8;
  localparam int WW  = (OFS_W + 15) / 16;
  localparam int PW  = (2 * WN > 2) ? $clog2(2 * WN) : 1;
  localparam int SCW = $clog2(2 * OFS_W + 1);

  ofsStb_t stb;
  logic [SCW-1:0] serBit;
  logic [PW-1:0]  wrPtr, rdPtr;

  ofs_ctrl #(.OFS_W(OFS_W), .SCW(SCW), .PW(PW), .WN(WN), .WW(WW)) uCtrl (
    .clk(clk), .mstRst(mstRst), .ofsLd(ofsLd),
    .wrWideIn(wrWideIn), .rdWideIn(rdWideIn), .parityIn(parityIn),
    .serEn(serEn), .wrEn(wrEn), .rdEn(rdEn),
    .stb(stb), .serBit(serBit), .wrPtr(wrPtr), .rdPtr(rdPtr)
  );

  ofs_dpath #(.DEPTH(DEPTH), .OFS_W(OFS_W), .SCW(SCW), .PW(PW), .WN(WN), .WW(WW)) uDpath (
    .clk(clk), .mstRst(mstRst), .ofsLd(ofsLd), .fsel1(fsel1), .fsel0(fsel0),
    .stb(stb), .serBit(serBit), .serIn(serIn), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .dIn(dIn), .emptyOfs(emptyOfs), .fullOfs(fullOfs), .rdData(rdData)
  );

endmodule

// File: tb/sim_ofs_loader.sv
`timescale 1ns/1ps
module sim_ofs_loader;

  logic clk = 1'b0;
  logic mstRst = 1'b1, ofsLd = 1'b0, fsel0 = 1'b0, fsel1 = 1'b0;
  logic wrWideIn = 1'b0, rdWideIn = 1'b0, parityIn = 1'b0;
  logic serEn = 1'b0, serIn = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [17:0] dIn = '0;
  logic [9:0] emptyOfs, fullOfs;
  logic [17:0] rdData;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  ofs_loader #(.DEPTH(1024)) u0 (
    .clk(clk), .mstRst(mstRst), .ofsLd(ofsLd), .fsel0(fsel0), .fsel1(fsel1),
    .wrWideIn(wrWideIn), .rdWideIn(rdWideIn), .parityIn(parityIn),
    .serEn(serEn), .serIn(serIn), .wrEn(wrEn), .dIn(dIn), .rdEn(rdEn),
    .emptyOfs(emptyOfs), .fullOfs(fullOfs), .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic doReset(input logic [2:0] k, input logic ww, input logic rw, input logic par);
    @(negedge clk);
    mstRst = 1'b1; {ofsLd, fsel1, fsel0} = k;
    wrWideIn = ww; rdWideIn = rw; parityIn = par;
    serEn = 0; wrEn = 0; rdEn = 0;
    @(negedge clk); @(negedge clk);
    mstRst = 1'b0; ofsLd = 1'b0; fsel0 = 0; fsel1 = 0;
    wrWideIn = ~ww; rdWideIn = ~rw; parityIn = ~par;  // must not matter after reset
    @(negedge clk);
  endtask

  task automatic wrWord(input logic [17:0] d);
    wrEn = 1'b1; dIn = d;
    @(negedge clk);
    wrEn = 1'b0; dIn = '0;
  endtask

  task automatic rdWord();
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic shiftBits(input logic [31:0] v, input int n);
    for (int b = 0; b < n; b++) begin
      serEn = 1'b1; serIn = v[b];
      @(negedge clk);
    end
    serEn = 1'b0; serIn = 1'b0;
  endtask

  task automatic tDefaults();
    for (int k = 0; k < 8; k++) begin
      int e;
      e = (1 << (k + 3)) - 1;
      if (e > 1023) e = 1023;
      doReset(3'(k), 1'b0, 1'b0, 1'b0);
      check("R2 empty default", 32'(emptyOfs), 32'(e));
      check("R2 full default", 32'(fullOfs), 32'(e));
      check("R2 rdData reset", 32'(rdData), 32'h0);
    end
  endtask

  task automatic tSerial();
    doReset(3'b100, 1'b0, 1'b1, 1'b0);  // serial (R1), wide read, no parity
    check("R2 serial default", 32'(emptyOfs), 32'd127);
    ofsLd = 1'b1;
    shiftBits(32'h2A5, 10);
    check("R3 empty after 10 bits", 32'(emptyOfs), 32'h2A5);
    check("R3 full untouched", 32'(fullOfs), 32'd127);
    shiftBits(32'h15A, 10);
    check("R3 full loaded", 32'(fullOfs), 32'h15A);
    shiftBits(32'h3FF, 3);
    check("R4 extra bits ignored e", 32'(emptyOfs), 32'h2A5);
    check("R4 extra bits ignored f", 32'(fullOfs), 32'h15A);
    wrWord(18'h00000);
    check("R8 wrEn in serial mode", 32'(emptyOfs), 32'h2A5);
    rdWord();
    check("R7 serial readback empty", 32'(rdData), 32'h002A5);
    rdWord();
    check("R7 serial readback full", 32'(rdData), 32'h0015A);
    ofsLd = 1'b0; @(negedge clk); ofsLd = 1'b1;
    shiftBits(32'h3FF, 10);
    check("R4 restart empty", 32'(emptyOfs), 32'h3FF);
    check("R4 restart full kept", 32'(fullOfs), 32'h15A);
    ofsLd = 1'b0;
  endtask

  task automatic tNarrow();
    doReset(3'b000, 1'b0, 1'b0, 1'b0);  // parallel, narrow both
    ofsLd = 1'b1;
    wrWord(18'h3FF34);
    wrWord(18'h3FE02);
    wrWord(18'h00178);
    wrWord(18'h2AA01);
    check("R5 narrow empty", 32'(emptyOfs), 32'h234);
    check("R6 narrow full", 32'(fullOfs), 32'h178);
    serEn = 1'b1; serIn = 1'b1; @(negedge clk); serEn = 1'b0; serIn = 1'b0;
    check("R8 serEn in parallel mode", 32'(emptyOfs), 32'h234);
    rdWord(); check("R7 narrow rd0", 32'(rdData), 32'h34);
    rdWord(); check("R7 narrow rd1", 32'(rdData), 32'h02);
    rdWord(); check("R7 narrow rd2", 32'(rdData), 32'h78);
    rdWord(); check("R7 narrow rd3", 32'(rdData), 32'h01);
    rdWord(); check("R10 read wrap", 32'(rdData), 32'h34);
    ofsLd = 1'b0;
    wrEn = 1; rdEn = 1; serEn = 1; serIn = 1; dIn = '0;
    @(negedge clk);
    wrEn = 0; rdEn = 0; serEn = 0; serIn = 0;
    check("R9 gated empty", 32'(emptyOfs), 32'h234);
    check("R9 gated full", 32'(fullOfs), 32'h178);
    check("R9 gated rdData", 32'(rdData), 32'h34);
    ofsLd = 1'b1;
    wrWord(18'h00099);
    ofsLd = 1'b0; @(negedge clk); ofsLd = 1'b1;
    wrWord(18'h00011);
    check("R10 pointer rewind", 32'(emptyOfs), 32'h211);
    check("R10 rewind full kept", 32'(fullOfs), 32'h178);
    ofsLd = 1'b0;
  endtask

  task automatic tWidePar();
    doReset(3'b011, 1'b1, 1'b1, 1'b1);
    ofsLd = 1'b1;
    wrWord(18'h20355);
    wrWord(18'h207AA);
    check("R6 parity empty", 32'(emptyOfs), 32'h155);
    check("R6 parity full", 32'(fullOfs), 32'h3AA);
    rdWord(); check("R7 parity rd0", 32'(rdData), 32'h00255);
    rdWord(); check("R7 parity rd1", 32'(rdData), 32'h006AA);
    ofsLd = 1'b0;
  endtask

  task automatic tWidePlain();
    doReset(3'b001, 1'b1, 1'b1, 1'b0);
    ofsLd = 1'b1;
    wrWord(18'h301C3);
    wrWord(18'h20270);
    check("R6 plain empty", 32'(emptyOfs), 32'h1C3);
    check("R5 plain full", 32'(fullOfs), 32'h270);
    wrWord(18'h00011);
    check("R10 write wrap", 32'(emptyOfs), 32'h011);
    check("R10 write wrap full", 32'(fullOfs), 32'h270);
    rdWord(); check("R7 plain rd0", 32'(rdData), 32'h00011);
    rdWord(); check("R7 plain rd1", 32'(rdData), 32'h00270);
    ofsLd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tDefaults();
    tSerial();
    tNarrow();
    tWidePar();
    tWidePlain();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule